// File: doc/BRIEF.md
# Filtered Edge Timestamp Capture

This block records when an edge occurs on an asynchronous input pin. It reads the time from a free-running count that a separate counter supplies. The pin first passes through a synchroniser. An optional digital filter can then be switched in. The filter only lets the pin's level change after that level has been held steadily for a fixed run of clock cycles.

When the selected edge polarity appears on the resulting level, the block does two things in the same cycle:
- it stores the count value present at that clock edge in a capture register;
- it raises a capture flag.

The flag drives an interrupt request when the interrupt is enabled. Software clears the flag either by writing a one to it or by acknowledging the interrupt.

The capture register can also serve as the period limit of the counter. For that use, a disable input is asserted. While it is asserted, the pin has no effect and the CPU may load the register directly. All pins are plain control and status signals. The capture value is a level that holds until the next capture or write, so the block has no handshake and applies no back-pressure.

Top module: `icap_unit`

## Requirements
- R1: After reset, `cap_value` is 0, `cap_flag` is 0 and `irq` is 0.
- R2: With the filter off, a pin level that settles before clock edge k is captured at edge k+2. The value stored is the `count_in` present at edge k+2, and `cap_flag` is high after that edge.
- R3: `edge_rise`=1 captures only low-to-high transitions of the level. `edge_rise`=0 captures only high-to-low transitions.
- R4: On a capture, `cap_value` takes the `count_in` value sampled at the capture edge, and `cap_flag` becomes 1.
- R5: With `filt_en`=1, the filtered level only follows the pin after four consecutive synchronised samples agree. A pulse of 1 to 3 cycles causes no capture. A pulse of 4 or more cycles causes one.
- R6: Enabling the filter delays a capture by exactly four clock cycles, to edge k+6.
- R7: While `cap_disable`=1, pin transitions cause no capture: `cap_value` and `cap_flag` do not change. Clearing `cap_disable` while the pin holds a steady level causes no capture.
- R8: `cpu_wr`=1 loads `cpu_wr_data` into `cap_value` at the next edge, but only while `cap_disable`=1. When `cap_disable`=0, the write is ignored.
- R9: `flag_clr`=1 or `irq_ack`=1 clears `cap_flag` at the next edge. If a capture happens in the same cycle, the capture wins and the flag stays 1.
- R10: `irq` equals `cap_flag` AND `irq_en`.
- R11: Changing `edge_rise` while the pin level is steady causes no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 1 | Asynchronous capture pin |
| count_in | input | CNT_W | Running count value to timestamp with |
| filt_en | input | 1 | 1 enables the four-sample noise filter |
| edge_rise | input | 1 | 1 selects rising edges, 0 selects falling edges |
| cap_disable | input | 1 | 1 when the capture register is used as the count limit |
| cpu_wr | input | 1 | CPU write strobe for the capture register |
| cpu_wr_data | input | CNT_W | CPU write data |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| irq_en | input | 1 | Interrupt enable |
| cap_value | output | CNT_W | Captured count |
| cap_flag | output | 1 | Capture flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 16-bit count, a four-sample filter and a two-stage synchroniser. It drives `count_in` from its own cycle counter, so the expected timestamp of every capture is simply the start cycle plus the latency from R2 or R6.

With these small settings, the bench can cover several things exhaustively:
- every combination of filter enable, edge polarity and transition direction;
- every pulse width from 1 to 6 cycles, on both sides of the filter threshold;
- the cycle just before each expected capture, to pin down the exact latency.

// File: rtl/icap_pkg.sv
package icap_pkg;
  // Edge qualifier: a capture happens when the level moves and lands on the selected polarity
  function automatic logic edge_hit(input logic prev_lvl, input logic cur_lvl, input logic want_rise);
    return (prev_lvl != cur_lvl) && (cur_lvl == want_rise);
  endfunction
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= din;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
  parameter int SAMPLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic level
);
  localparam int HIST = SAMPLES - 1;

  logic [HIST-1:0] hist;
  logic            filt_q;
  logic            all_hi, all_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else if (HIST == 1) hist <= din;
    else hist <= {hist[HIST-1:0], din};
  end

  assign all_hi = din & (&hist);
  assign all_lo = ~din & ~(|hist);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) filt_q <= 1'b0;
    else if (all_hi) filt_q <= 1'b1;
    else if (all_lo) filt_q <= 1'b0;
  end

  assign level = en ? filt_q : din;

  // R5: the filtered level only moves after a full run of agreeing samples
  a_r5_change_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> $past(all_hi || all_lo));
endmodule

// File: rtl/icap_edge.sv
module icap_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic want_rise,
  input  logic block,
  output logic trig
);
  import icap_pkg::*;
  logic prev_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_lvl <= 1'b0;
    else prev_lvl <= level;
  end

  assign trig = !block && edge_hit(prev_lvl, level, want_rise);
endmodule

// File: rtl/icap_unit.sv
module icap_unit #(
  parameter int CNT_W        = 16,
  parameter int FILT_SAMPLES = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_pin,
  input  logic [CNT_W-1:0] count_in,
  input  logic             filt_en,
  input  logic             edge_rise,
  input  logic             cap_disable,
  input  logic             cpu_wr,
  input  logic [CNT_W-1:0] cpu_wr_data,
  input  logic             flag_clr,
  input  logic             irq_ack,
  input  logic             irq_en,
  output logic [CNT_W-1:0] cap_value,
  output logic             cap_flag,
  output logic             irq
);
  logic pin_sync, pin_level, trig;

  icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(cap_pin), .dout(pin_sync));

  icap_filter #(.SAMPLES(FILT_SAMPLES)) u_filt (
    .clk(clk), .rst_n(rst_n), .en(filt_en), .din(pin_sync), .level(pin_level));

  icap_edge u_edge (
    .clk(clk), .rst_n(rst_n), .level(pin_level), .want_rise(edge_rise),
    .block(cap_disable), .trig(trig));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_value <= '0;
    else if (trig) cap_value <= count_in;
    else if (cap_disable && cpu_wr) cap_value <= cpu_wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_flag <= 1'b0;
    else if (trig) cap_flag <= 1'b1;
    else if (flag_clr || irq_ack) cap_flag <= 1'b0;
  end

  assign irq = cap_flag & irq_en;

  a_r4_stamp: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> cap_value == $past(count_in));
  a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> cap_flag);
  a_r7_no_flag_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    cap_disable && !cap_flag |=> !cap_flag);
  a_r8_cpu_load: assert property (@(posedge clk) disable iff (!rst_n)
    cap_disable && cpu_wr |=> cap_value == $past(cpu_wr_data));
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr || irq_ack) && !trig |=> !cap_flag);
  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cap_flag);
endmodule

// File: tb/tb_icap_unit.sv
module tb_icap_unit;
  localparam int W = 16;
  logic clk = 0, rst_n = 0;
  logic cap_pin = 0, filt_en = 0, edge_rise = 1, cap_disable = 0;
  logic cpu_wr = 0, flag_clr = 0, irq_ack = 0, irq_en = 0;
  logic [W-1:0] cpu_wr_data = '0, cnt = '0;
  logic [W-1:0] cap_value;
  logic cap_flag, irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 1'b1;

  icap_unit dut (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .count_in(cnt),
    .filt_en(filt_en), .edge_rise(edge_rise), .cap_disable(cap_disable),
    .cpu_wr(cpu_wr), .cpu_wr_data(cpu_wr_data), .flag_clr(flag_clr),
    .irq_ack(irq_ack), .irq_en(irq_en), .cap_value(cap_value),
    .cap_flag(cap_flag), .irq(irq));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic clear_flag();
    flag_clr = 1; cyc(1); flag_clr = 0;
  endtask

  // Drive a level change and check latency, value and flag
  task automatic drive_edge(input logic lvl, input int lat, input bit expect_cap, input string req);
    logic [W-1:0] old, n;
    clear_flag();
    old = cap_value;
    n = cnt;
    cap_pin = lvl;
    cyc(lat);
    check(cap_flag == 0, {req, " early"}, cap_flag, 0);
    cyc(1);
    if (expect_cap) begin
      check(cap_flag == 1, {req, " flag"}, cap_flag, 1);
      check(cap_value == W'(n + lat), {req, " value"}, cap_value, W'(n + lat));
    end else begin
      check(cap_flag == 0, {req, " none"}, cap_flag, 0);
      check(cap_value == old, {req, " kept"}, cap_value, old);
    end
    cyc(8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cap_value == 0 && cap_flag == 0 && irq == 0, "R1 reset", {cap_value, cap_flag, irq}, 0);
    rst_n = 1;
    cyc(8);

    // R2 R3 R4 R6: sweep filter x polarity x direction
    for (int f = 0; f < 2; f++) begin
      for (int er = 0; er < 2; er++) begin
        filt_en = f[0]; edge_rise = er[0];
        cyc(2);
        drive_edge(1'b1, f ? 6 : 2, er == 1, f ? "R6 R3 rise" : "R2 R3 rise");
        drive_edge(1'b0, f ? 6 : 2, er == 0, f ? "R6 R4 fall" : "R2 R4 fall");
      end
    end

    // R5 pulse width sweep, rising edges, with and without filter
    edge_rise = 1;
    for (int f = 0; f < 2; f++) begin
      filt_en = f[0];
      for (int w = 1; w <= 6; w++) begin
        clear_flag();
        cap_pin = 1; cyc(w); cap_pin = 0;
        cyc(12);
        check(cap_flag == ((f == 0) || (w >= 4)), "R5 pulse", cap_flag, (f == 0) || (w >= 4));
      end
    end
    filt_en = 0;

    // R11: flip polarity with steady level
    clear_flag();
    cap_pin = 1; cyc(6); clear_flag();
    edge_rise = 0; cyc(4); edge_rise = 1; cyc(4);
    check(cap_flag == 0, "R11 select change", cap_flag, 0);

    // R7 disabled: falling then rising ignored, re-enable with steady pin
    cap_disable = 1;
    drive_edge(1'b0, 2, 0, "R7 disabled fall");
    drive_edge(1'b1, 2, 0, "R7 disabled rise");
    // R8 CPU write while disabled
    cpu_wr_data = 16'h1234; cpu_wr = 1; cyc(1); cpu_wr = 0;
    check(cap_value == 16'h1234, "R8 write disabled", cap_value, 16'h1234);
    cap_disable = 0; cyc(4);
    check(cap_flag == 0, "R7 re-enable", cap_flag, 0);
    cpu_wr_data = 16'h5678; cpu_wr = 1; cyc(1); cpu_wr = 0;
    check(cap_value == 16'h1234, "R8 write ignored", cap_value, 16'h1234);

    // R10 irq gating, R9 clear by ack
    cap_pin = 0; cyc(6); cap_pin = 1; cyc(4);
    check(cap_flag == 1 && irq == 0, "R10 irq masked", irq, 0);
    irq_en = 1; #1;
    check(irq == 1, "R10 irq on", irq, 1);
    irq_ack = 1; cyc(1); irq_ack = 0;
    check(cap_flag == 0 && irq == 0, "R9 ack clears", cap_flag, 0);

    // R9 capture beats a simultaneous clear
    cap_pin = 0; cyc(6);
    flag_clr = 1;
    cap_pin = 1; cyc(3);
    check(cap_flag == 1, "R9 capture wins", cap_flag, 1);
    cyc(1);
    check(cap_flag == 0, "R9 clear after", cap_flag, 0);
    flag_clr = 0; irq_en = 0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule